// File: doc/BRIEF.md
# Two-level page table walker

This block turns a 32-bit virtual address into a 32-bit physical address by reading a two-level short-format translation table from memory. A requester offers a virtual address, a 3-bit split field and two table base values on a valid/ready handshake. The walker then reads one or two 32-bit descriptors through a memory port that has at most one read in flight. It returns the physical address with a one-cycle completion pulse, or reports a fault code that says which level failed.

The split field N divides the address space between the two bases. Addresses up to `0xFFFFFFFF >> N` use the low base. All higher addresses use the high base. The first descriptor is decoded as one of four things: a fault, a 1 MB section, a 16 MB supersection, or a pointer to a second-level table. A second-level descriptor gives a 64 KB large page, a 4 KB small page, or a fault.

Back-pressure on the request side works as follows. `req_ready` is high only while the walker is idle. A request is taken on the clock edge where `req_valid` and `req_ready` are both high. While `req_valid` is high and `req_ready` is low, the requester keeps all request fields stable. The result side cannot be stalled: `walk_done` is a pulse, and the consumer must take the result in that cycle. On the memory side, `mem_rd_req` is a one-cycle pulse. `mem_rd_addr` stays unchanged until the reply arrives. A reply is a single cycle with `mem_rsp_valid` high, at least one cycle after the request. A reply that arrives while no read is outstanding is ignored.

Top module: `ptw_walker`

## Requirements
- R1: `req_ready` is 1 after reset and while idle. It is 0 from the cycle after a request is accepted until the walk has finished.
- R2: With N = `req_split`, a virtual address at or below `0xFFFFFFFF >> N` selects the low base ANDed with `0xFFFFFFFF << (14-N)`. Any higher address selects the high base ANDed with `0xFFFFFFFF << 14`.
- R3: The first read address is the masked base ORed with ((va AND `0xFFF00000` AND limit) >> 18). The limit is `0xFFFFFFFF >> N` for the low base and `0xFFFFFFFF` for the high base.
- R4: A first-level descriptor with bits [1:0] = 00 ends the walk after one read with `walk_fault` = 1.
- R5: A first-level descriptor with bit 1 = 1 and bit 18 = 0 is a section. The result is {desc[31:20], va[19:0]} after one read.
- R6: A first-level descriptor with bit 1 = 1 and bit 18 = 1 is a supersection. The result is {desc[31:24], va[23:0]} after one read.
- R7: A supersection with any bit set in desc[23:20] or desc[8:5] ends the walk with `walk_fault` = 1.
- R8: A first-level descriptor with bits [1:0] = 01 leads to a second read at {desc[31:10], va[19:12], 2'b00}.
- R9: A second-level descriptor with bits [1:0] = 00 ends the walk after two reads with `walk_fault` = 2.
- R10: A second-level descriptor with bits [1:0] = 01 is a large page. The result is {desc[31:16], va[15:0]}.
- R11: A second-level descriptor with bits [1:0] = 10 or 11 is a small page. The result is {desc[31:12], va[11:0]}.
- R12: `mem_rd_req` is a one-cycle pulse. No new request is issued until the reply arrives, and `mem_rd_addr` stays stable while the read is outstanding. Sections, supersections and first-level faults use one read; page results and second-level faults use two.
- R13: `walk_done` is high for exactly one cycle per accepted request. With it, `walk_fault` is 0 on success. On a fault, `walk_fault` is nonzero and `walk_pa` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Walker idle and able to accept |
| req_va | input | 32 | Virtual address to translate |
| req_split | input | 3 | Split field N dividing the address space between the two bases |
| req_base_lo | input | 32 | Table base for the low address range |
| req_base_hi | input | 32 | Table base for the high address range |
| mem_rd_req | output | 1 | One-cycle descriptor read request |
| mem_rd_addr | output | 32 | Descriptor byte address |
| mem_rsp_valid | input | 1 | Descriptor reply valid |
| mem_rsp_data | input | 32 | Descriptor value |
| walk_done | output | 1 | One-cycle completion pulse |
| walk_pa | output | 32 | Physical address (0 on fault) |
| walk_fault | output | 2 | 0 = success, 1 = first-level fault, 2 = second-level fault |

## Verification
The walks cover each first-level type: a section, including one with bit 0 set; a supersection with harmless low bits; supersections that set an extension bit in either of the two forbidden fields; and both an all-zero and a nonzero fault pattern. This shows that decoding looks only at bits 1, 0 and 18. Table pointers lead to large pages, to small pages with both 10 and 11 codes, and to second-level faults. These prove that the second read address uses the right descriptor and virtual-address bits, and that the page size follows bits [1:0]. Split values of 0, 2 and 7 are tried, with base values that carry bits the mask must drop. Addresses sit exactly at the limit and one above it, which tells base selection and masking apart. Reply latency varies between walks, and the number of reads is compared for every walk.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int ADDR_W     = 32;
  localparam int SPLIT_W    = 3;
  localparam int FLT_W      = 2;
  localparam int BASE_ALIGN = 14;  // minimum table alignment (log2 bytes)
  localparam int SEC_LSB    = 20;  // section index / offset boundary
  localparam int SUP_LSB    = 24;  // supersection offset boundary
  localparam int L1_SHIFT   = 18;  // section index to byte offset shift
  localparam int L2_TBL_LSB = 10;  // second-level table alignment
  localparam int LRG_LSB    = 16;  // large page offset boundary
  localparam int SML_LSB    = 12;  // small page offset boundary
  localparam int SUPER_BIT  = 18;  // descriptor bit telling super from section

  localparam logic [FLT_W-1:0] FLT_NONE = 2'd0;
  localparam logic [FLT_W-1:0] FLT_LVL1 = 2'd1;
  localparam logic [FLT_W-1:0] FLT_LVL2 = 2'd2;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD1, ST_WAIT1, ST_RD2, ST_WAIT2, ST_DONE
  } walk_st_t;

  typedef enum logic [1:0] {
    K1_FAULT, K1_SECTION, K1_SUPER, K1_TABLE
  } l1_kind_t;
endpackage

// File: rtl/ptw_base_sel.sv
module ptw_base_sel
  import ptw_pkg::*;
(
  input  logic [ADDR_W-1:0]  va,
  input  logic [SPLIT_W-1:0] split,
  input  logic [ADDR_W-1:0]  base_lo,
  input  logic [ADDR_W-1:0]  base_hi,
  output logic               use_hi,
  output logic [ADDR_W-1:0]  l1_addr
);
  localparam logic [ADDR_W-1:0] ALL_ONES = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] IDX_MASK = ALL_ONES << SEC_LSB;

  logic [ADDR_W-1:0] lo_limit;
  logic [ADDR_W-1:0] lo_mask;
  logic [ADDR_W-1:0] hi_mask;
  logic [4:0]        lo_shift;

  always_comb begin
    lo_limit = ALL_ONES >> split;
    lo_shift = 5'(BASE_ALIGN) - {2'b00, split};
    lo_mask  = ALL_ONES << lo_shift;
    hi_mask  = ALL_ONES << BASE_ALIGN;
    use_hi   = va > lo_limit;
    if (use_hi)
      l1_addr = (base_hi & hi_mask) | ((va & IDX_MASK) >> L1_SHIFT);
    else
      l1_addr = (base_lo & lo_mask) | ((va & IDX_MASK & lo_limit) >> L1_SHIFT);
  end
endmodule

// File: rtl/ptw_l1_decode.sv
module ptw_l1_decode
  import ptw_pkg::*;
(
  input  logic [ADDR_W-1:0] desc,
  input  logic [ADDR_W-1:0] va,
  output l1_kind_t          kind,
  output logic              too_wide,
  output logic [ADDR_W-1:0] blk_pa,
  output logic [ADDR_W-1:0] l2_addr
);
  logic unused_l1;
  assign unused_l1 = ^{desc[9], desc[4:2], va[ADDR_W-1:SUP_LSB]};

  always_comb begin
    if (desc[1:0] == 2'b00)
      kind = K1_FAULT;
    else if (desc[1] && !desc[SUPER_BIT])
      kind = K1_SECTION;
    else if (desc[1])
      kind = K1_SUPER;
    else
      kind = K1_TABLE;

    too_wide = (|desc[23:20]) | (|desc[8:5]);

    if (kind == K1_SUPER)
      blk_pa = {desc[ADDR_W-1:SUP_LSB], va[SUP_LSB-1:0]};
    else
      blk_pa = {desc[ADDR_W-1:SEC_LSB], va[SEC_LSB-1:0]};

    l2_addr = {desc[ADDR_W-1:L2_TBL_LSB], va[SEC_LSB-1:SML_LSB], 2'b00};
  end
endmodule

// File: rtl/ptw_l2_decode.sv
module ptw_l2_decode
  import ptw_pkg::*;
(
  input  logic [ADDR_W-1:0] desc,
  input  logic [ADDR_W-1:0] va,
  output logic              fault,
  output logic [ADDR_W-1:0] page_pa
);
  logic unused_l2;
  assign unused_l2 = ^{desc[SML_LSB-1:2], va[ADDR_W-1:LRG_LSB]};

  always_comb begin
    fault = (desc[1:0] == 2'b00);
    if (desc[1:0] == 2'b01)
      page_pa = {desc[ADDR_W-1:LRG_LSB], va[LRG_LSB-1:0]};
    else
      page_pa = {desc[ADDR_W-1:SML_LSB], va[SML_LSB-1:0]};
  end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [ADDR_W-1:0]  req_va,
  input  logic [SPLIT_W-1:0] req_split,
  input  logic [ADDR_W-1:0]  req_base_lo,
  input  logic [ADDR_W-1:0]  req_base_hi,
  output logic               mem_rd_req,
  output logic [ADDR_W-1:0]  mem_rd_addr,
  input  logic               mem_rsp_valid,
  input  logic [ADDR_W-1:0]  mem_rsp_data,
  output logic               walk_done,
  output logic [ADDR_W-1:0]  walk_pa,
  output logic [FLT_W-1:0]   walk_fault
);
  walk_st_t          st;
  logic [ADDR_W-1:0] va_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] pa_q;
  logic [FLT_W-1:0]  flt_q;

  logic              sel_hi;
  logic [ADDR_W-1:0] sel_l1_addr;
  l1_kind_t          l1_kind;
  logic              l1_wide;
  logic [ADDR_W-1:0] l1_pa;
  logic [ADDR_W-1:0] l1_next;
  logic              l2_fault;
  logic [ADDR_W-1:0] l2_pa;
  logic              unused_top;
  assign unused_top = sel_hi;

  ptw_base_sel u_base (
    .va(req_va), .split(req_split), .base_lo(req_base_lo), .base_hi(req_base_hi),
    .use_hi(sel_hi), .l1_addr(sel_l1_addr)
  );

  ptw_l1_decode u_l1 (
    .desc(mem_rsp_data), .va(va_q), .kind(l1_kind), .too_wide(l1_wide),
    .blk_pa(l1_pa), .l2_addr(l1_next)
  );

  ptw_l2_decode u_l2 (
    .desc(mem_rsp_data), .va(va_q), .fault(l2_fault), .page_pa(l2_pa)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      va_q   <= '0;
      addr_q <= '0;
      pa_q   <= '0;
      flt_q  <= FLT_NONE;
    end else begin
      case (st)
        ST_IDLE: if (req_valid) begin
          va_q   <= req_va;
          addr_q <= sel_l1_addr;
          st     <= ST_RD1;
        end
        ST_RD1: st <= ST_WAIT1;
        ST_WAIT1: if (mem_rsp_valid) begin
          case (l1_kind)
            K1_FAULT: begin
              pa_q  <= '0;
              flt_q <= FLT_LVL1;
              st    <= ST_DONE;
            end
            K1_SECTION: begin
              pa_q  <= l1_pa;
              flt_q <= FLT_NONE;
              st    <= ST_DONE;
            end
            K1_SUPER: begin
              pa_q  <= l1_wide ? '0 : l1_pa;
              flt_q <= l1_wide ? FLT_LVL1 : FLT_NONE;
              st    <= ST_DONE;
            end
            default: begin
              addr_q <= l1_next;
              st     <= ST_RD2;
            end
          endcase
        end
        ST_RD2: st <= ST_WAIT2;
        ST_WAIT2: if (mem_rsp_valid) begin
          pa_q  <= l2_fault ? '0 : l2_pa;
          flt_q <= l2_fault ? FLT_LVL2 : FLT_NONE;
          st    <= ST_DONE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign req_ready   = (st == ST_IDLE);
  assign mem_rd_req  = (st == ST_RD1) || (st == ST_RD2);
  assign mem_rd_addr = addr_q;
  assign walk_done   = (st == ST_DONE);
  assign walk_pa     = pa_q;
  assign walk_fault  = flt_q;

  // R1: an accepted request closes the handshake
  p_ready_low_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R12: read request is a single-cycle pulse
  p_rd_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req |=> !mem_rd_req);

  // R12: address held while a read is outstanding
  p_rd_addr_stable_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && !mem_rd_req) |-> $stable(mem_rd_addr));

  // R13: completion is a pulse
  p_done_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n)
    walk_done |=> !walk_done);

  // R13: faulted result carries a zero address
  p_fault_zero_pa_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_done && walk_fault != FLT_NONE) |-> (walk_pa == '0));

  // R4: empty first-level entry faults at level one
  p_l1_fault_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAIT1 && mem_rsp_valid && mem_rsp_data[1:0] == 2'b00)
      |=> (walk_done && walk_fault == FLT_LVL1));

  // R5: section result composition
  p_section_pa_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAIT1 && mem_rsp_valid && mem_rsp_data[1] && !mem_rsp_data[SUPER_BIT])
      |=> (walk_done && walk_fault == FLT_NONE &&
           walk_pa == {$past(mem_rsp_data[ADDR_W-1:SEC_LSB]), $past(va_q[SEC_LSB-1:0])}));

  // R8: table pointer issues the second read at the composed address
  p_l2_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAIT1 && mem_rsp_valid && mem_rsp_data[1:0] == 2'b01)
      |=> (mem_rd_req && mem_rd_addr ==
           {$past(mem_rsp_data[ADDR_W-1:L2_TBL_LSB]), $past(va_q[SEC_LSB-1:SML_LSB]), 2'b00}));

  // R9: empty second-level entry faults at level two
  p_l2_fault_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAIT2 && mem_rsp_valid && mem_rsp_data[1:0] == 2'b00)
      |=> (walk_done && walk_fault == FLT_LVL2));
endmodule

// File: tb/ptw_walker_test.sv
module ptw_walker_test;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [31:0] req_va;
  logic [2:0]  req_split;
  logic [31:0] req_base_lo;
  logic [31:0] req_base_hi;
  logic        mem_rd_req;
  logic [31:0] mem_rd_addr;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_data;
  logic        walk_done;
  logic [31:0] walk_pa;
  logic [1:0]  walk_fault;

  ptw_walker uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_va(req_va), .req_split(req_split), .req_base_lo(req_base_lo),
    .req_base_hi(req_base_hi), .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .walk_done(walk_done), .walk_pa(walk_pa), .walk_fault(walk_fault)
  );

  typedef struct packed {
    logic [31:0] pa;
    logic [1:0]  flt;
    logic [1:0]  reads;
  } exp_t;

  exp_t        exp_q[$];
  string       exp_tag_q[$];
  logic [31:0] addr_exp_q[$];
  string       addr_tag_q[$];
  logic [31:0] mem [logic [31:0]];

  int n_cmp = 0;
  int n_bad = 0;
  int lat = 1;
  int reads_seen = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
    end
  endtask

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  // R2/R3 address model
  function automatic logic [31:0] l1_addr_of(input logic [31:0] va, input logic [2:0] n,
                                             input logic [31:0] b0, input logic [31:0] b1);
    logic [31:0] lim;
    lim = 32'hFFFF_FFFF >> n;
    if (va <= lim)
      return (b0 & (32'hFFFF_FFFF << (14 - n))) | ((va & 32'hFFF0_0000 & lim) >> 18);
    else
      return (b1 & 32'hFFFF_C000) | ((va & 32'hFFF0_0000) >> 18);
  endfunction

  function automatic logic [31:0] l2_addr_of(input logic [31:0] d1, input logic [31:0] va);
    return (d1 & 32'hFFFF_FC00) | ((va & 32'h000F_F000) >> 10);
  endfunction

  // memory responder
  initial begin
    bit          pend;
    int          wait_n;
    logic [31:0] hold_a;
    pend = 1'b0;
    wait_n = 0;
    hold_a = '0;
    mem_rsp_valid = 1'b0;
    mem_rsp_data = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (pend) begin
        if (wait_n <= 1) begin
          mem_rsp_data = rd(hold_a);
          mem_rsp_valid = 1'b1;
          pend = 1'b0;
        end else wait_n--;
      end
      if (mem_rd_req) begin
        reads_seen++;
        if (pend) check(1'b0, "R12", "request while read outstanding", 32'h1, 32'h0);
        if (addr_exp_q.size() != 0) begin
          logic [31:0] ea;
          string       et;
          ea = addr_exp_q.pop_front();
          et = addr_tag_q.pop_front();
          check(mem_rd_addr == ea, et, "read address", mem_rd_addr, ea);
        end else check(1'b0, "R12", "unexpected read", mem_rd_addr, 32'h0);
        pend = 1'b1;
        wait_n = lat;
        hold_a = mem_rd_addr;
      end
    end
  end

  // result monitor (scoreboard)
  initial begin
    forever begin
      @(negedge clk);
      if (walk_done) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R13", "done without request", 32'h1, 32'h0);
        end else begin
          exp_t  e;
          string t;
          e = exp_q.pop_front();
          t = exp_tag_q.pop_front();
          check(walk_pa == e.pa, t, "physical address", walk_pa, e.pa);
          check(walk_fault == e.flt, t, "fault code", {30'd0, walk_fault}, {30'd0, e.flt});
          check(reads_seen == int'(e.reads), "R12", "read count",
                32'(reads_seen), {30'd0, e.reads});
        end
        reads_seen = 0;
        @(negedge clk);
        check(!walk_done, "R13", "done width", {31'd0, walk_done}, 32'h0);
      end
    end
  end

  // driver
  task automatic walk(input logic [31:0] va, input logic [2:0] n, input logic [31:0] b0,
                      input logic [31:0] b1, input logic [31:0] epa, input logic [1:0] eflt,
                      input logic [1:0] ereads, input string tag);
    logic [31:0] a1;
    exp_t        e;
    a1 = l1_addr_of(va, n, b0, b1);
    addr_exp_q.push_back(a1);
    addr_tag_q.push_back(tag);
    if (ereads == 2'd2) begin
      addr_exp_q.push_back(l2_addr_of(rd(a1), va));
      addr_tag_q.push_back("R8");
    end
    e.pa = epa;
    e.flt = eflt;
    e.reads = ereads;
    exp_q.push_back(e);
    exp_tag_q.push_back(tag);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_va = va;
    req_split = n;
    req_base_lo = b0;
    req_base_hi = b1;
    @(negedge clk);
    req_valid = 1'b0;
    check(!req_ready, "R1", "ready while busy", {31'd0, req_ready}, 32'h0);
    while (exp_q.size() != 0) @(negedge clk);
    lat = (lat % 3) + 1;
  endtask

  task automatic put_l1(input logic [31:0] va, input logic [2:0] n, input logic [31:0] b0,
                        input logic [31:0] b1, input logic [31:0] d);
    mem[l1_addr_of(va, n, b0, b1)] = d;
  endtask

  task automatic put_l2(input logic [31:0] d1, input logic [31:0] va, input logic [31:0] d2);
    mem[l2_addr_of(d1, va)] = d2;
  endtask

  localparam logic [31:0] B0A = 32'h0001_3FFF;
  localparam logic [31:0] B1A = 32'h0007_7777;
  localparam logic [31:0] B0B = 32'h0003_0ABC;
  localparam logic [31:0] B1B = 32'h0004_3FFF;
  localparam logic [31:0] B0C = 32'h0005_00FF;

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0;
    req_va = '0;
    req_split = '0;
    req_base_lo = '0;
    req_base_hi = '0;

    put_l1(32'h1234_5678, 3'd0, B0A, B1A, 32'h8760_0002);
    put_l1(32'h1244_5678, 3'd0, B0A, B1A, 32'h8760_0003);
    put_l1(32'h2345_6789, 3'd0, B0A, B1A, 32'hAB04_0002);
    put_l1(32'h2355_6789, 3'd0, B0A, B1A, 32'hAB14_0002);
    put_l1(32'h2365_6789, 3'd0, B0A, B1A, 32'hCD04_0022);
    put_l1(32'h2371_2345, 3'd0, B0A, B1A, 32'hCD04_1E1E);
    put_l1(32'h3010_0000, 3'd0, B0A, B1A, 32'hFFFF_FFFC);
    put_l1(32'h4012_3456, 3'd0, B0A, B1A, 32'h0002_0401);
    put_l2(32'h0002_0401, 32'h4012_3456, 32'h5555_0001);
    put_l2(32'h0002_0401, 32'h4013_4ABC, 32'h7777_7002);
    put_l2(32'h0002_0401, 32'h4015_6DEF, 32'h1234_5003);
    put_l2(32'h0002_0401, 32'h4018_1000, 32'hFFFF_FFFC);
    put_l1(32'h4020_1234, 3'd0, B0A, B1A, 32'h0003_07FD);
    put_l2(32'h0003_07FD, 32'h4020_1234, 32'hABCD_E002);
    put_l1(32'h3FFF_FFFF, 3'd2, B0B, B1B, 32'h9990_0002);
    put_l1(32'h4000_0000, 3'd2, B0B, B1B, 32'h8880_0002);
    put_l1(32'h01F0_0000, 3'd7, B0C, B1B, 32'h1110_0002);
    put_l1(32'h0200_0000, 3'd7, B0C, B1B, 32'h2220_0002);

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready, "R1", "ready after reset", {31'd0, req_ready}, 32'h1);
    check(!walk_done, "R13", "done after reset", {31'd0, walk_done}, 32'h0);
    check(!mem_rd_req, "R12", "read after reset", {31'd0, mem_rd_req}, 32'h0);

    walk(32'h1234_5678, 3'd0, B0A, B1A, 32'h8764_5678, 2'd0, 2'd1, "R5");
    walk(32'h1244_5678, 3'd0, B0A, B1A, 32'h8764_5678, 2'd0, 2'd1, "R5");
    walk(32'h2345_6789, 3'd0, B0A, B1A, 32'hAB45_6789, 2'd0, 2'd1, "R6");
    walk(32'h2371_2345, 3'd0, B0A, B1A, 32'hCD71_2345, 2'd0, 2'd1, "R6");
    walk(32'h2355_6789, 3'd0, B0A, B1A, 32'h0000_0000, 2'd1, 2'd1, "R7");
    walk(32'h2365_6789, 3'd0, B0A, B1A, 32'h0000_0000, 2'd1, 2'd1, "R7");
    walk(32'h3000_0000, 3'd0, B0A, B1A, 32'h0000_0000, 2'd1, 2'd1, "R4");
    walk(32'h3010_0000, 3'd0, B0A, B1A, 32'h0000_0000, 2'd1, 2'd1, "R4");
    walk(32'h4012_3456, 3'd0, B0A, B1A, 32'h5555_3456, 2'd0, 2'd2, "R10");
    walk(32'h4013_4ABC, 3'd0, B0A, B1A, 32'h7777_7ABC, 2'd0, 2'd2, "R11");
    walk(32'h4015_6DEF, 3'd0, B0A, B1A, 32'h1234_5DEF, 2'd0, 2'd2, "R11");
    walk(32'h4017_0000, 3'd0, B0A, B1A, 32'h0000_0000, 2'd2, 2'd2, "R9");
    walk(32'h4018_1000, 3'd0, B0A, B1A, 32'h0000_0000, 2'd2, 2'd2, "R9");
    walk(32'h4020_1234, 3'd0, B0A, B1A, 32'hABCD_E234, 2'd0, 2'd2, "R8");
    walk(32'h3FFF_FFFF, 3'd2, B0B, B1B, 32'h999F_FFFF, 2'd0, 2'd1, "R2");
    walk(32'h4000_0000, 3'd2, B0B, B1B, 32'h8880_0000, 2'd0, 2'd1, "R2");
    walk(32'h01F0_0000, 3'd7, B0C, B1B, 32'h1110_0000, 2'd0, 2'd1, "R3");
    walk(32'h0200_0000, 3'd7, B0C, B1B, 32'h2220_0000, 2'd0, 2'd1, "R3");

    repeat (4) @(negedge clk);
    check(addr_exp_q.size() == 0, "R12", "reads left unissued",
          32'(addr_exp_q.size()), 32'h0);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL R13 watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule